// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Unit

This unit watches the digital outputs of a pair of analog comparators and tells software when either one has changed since it last looked. Each read of the control/status register takes a snapshot of both comparator outputs. From then on, the unit compares the live outputs with that snapshot. While they differ, a sticky interrupt flag is set. The flag can only be cleared once software has read the register again, which brings the snapshot up to date. The comparators themselves, their input multiplexing and the reference ladder are outside the unit. Their outputs arrive as asynchronous digital levels and are synchronized on entry.

A 3-bit mode field and an input-select bit sit in the same register. They are passed on to the analog side. Any write that changes either of them raises the flag, because the switching can disturb the comparator outputs. The interrupt output is the flag gated by an enable bit. The flag itself is set whether or not the interrupt is enabled.

The flag is controlled by a three-state machine:
- `FL_IDLE`: the flag is clear.
- `FL_RAISED`: the flag is set and a mismatch is live.
- `FL_ARMED`: the flag is set and no mismatch is live, so a clear will succeed.

Its transitions are:
- `raise`: `FL_IDLE` moves to `FL_RAISED` on a mismatch.
- `arm`: `FL_IDLE` moves to `FL_ARMED` on a mode change with no mismatch.
- `settle`: `FL_RAISED` moves to `FL_ARMED` once the mismatch ends.
- `rearm`: `FL_ARMED` moves to `FL_RAISED` when a mismatch reappears.
- `clear`: `FL_RAISED` or `FL_ARMED` moves to `FL_IDLE` on an accepted clear.

Any set condition wins over a clear in the same cycle.

Top module: `cmp_change_irq`

## Requirements
- R1: After reset the mode field is 3'b111 (comparators off), input-select is 0, the interrupt enable is 0, the flag is 0 and the snapshot is 00, so address 0 reads 0x07.
- R2: Address 0 layout: bits [2:0] hold the mode, bit 3 holds input-select, bit 4 shows comparator 0, bit 5 shows comparator 1, and bits 7:6 read 0. Every read of address 0 copies bits 5:4 into the snapshot, and nothing else changes the snapshot.
- R3: When a comparator output differs from its snapshot bit, the flag (address 1, bit 0) becomes 1 no later than three clock edges after the input change. It stays 1 even if the input returns to the snapshot value.
- R4: A clear attempt while a mismatch is live leaves the flag at 1.
- R5: A write of address 1 with bit 0 = 1 clears the flag when no mismatch and no set condition exist in that cycle. A write with bit 0 = 0 leaves the flag unchanged.
- R6: A write to address 0 that changes the mode field or the input-select bit sets the flag at that write's clock edge.
- R7: A write to address 0 that leaves both the mode and input-select unchanged does not set the flag.
- R8: The `irq` output equals the flag ANDed with the enable (address 2, bit 0). The flag sets regardless of the enable.
- R9: Writes to address 0 bits 7:4 are ignored, and address 3 reads 0x00.
- R10: In mode 3'b111 both comparator outputs read as 0 and are compared as 0, so input changes do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 2 | Asynchronous comparator outputs |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, 0 otherwise |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The bench builds the unit with its default parameters: two comparators, a 3-bit mode field and a two-stage synchronizer. These defaults make the three-edge path from input change to flag visible, and they give the off-mode encoding 3'b111 that R10 depends on. The sequence moves through every flag-state transition. It includes a mismatch that resolves by itself while the flag stays set, a clear attempted before the status read, an input-select toggle, a rewrite with unchanged settings, and a switch into the off mode while the snapshot holds ones.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_RAISED = 2'd1,
        FL_ARMED  = 2'd2
    } flag_state_e;

    localparam int REG_CTRL  = 0;
    localparam int REG_FLAG  = 1;
    localparam int REG_IEN   = 2;
    localparam int FLAG_BIT  = 0;
    localparam int IEN_BIT   = 0;

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q[0] <= d_async[b];
                for (int s = 1; s < STAGES; s++) begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end

        assign q_sync[b] = chain_q[LAST];
    end

endmodule

// File: rtl/cmpirq_regs.sv
module cmpirq_regs
    import cmpirq_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int MODE_W  = 3,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter logic [MODE_W-1:0] OFF_MODE = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_sync,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               flag,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CMP-1:0] cmp_live,
    output logic [NUM_CMP-1:0] cmp_ref,
    output logic [MODE_W-1:0]  mode,
    output logic               in_sel,
    output logic               reconfig,
    output logic               clr_req,
    output logic               irq_en
);

    localparam int ISEL_BIT = MODE_W;
    localparam int OUT_LSB  = MODE_W + 1;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);

    logic [MODE_W-1:0]  mode_q;
    logic               isel_q;
    logic               ien_q;
    logic [NUM_CMP-1:0] ref_q;
    logic               wr_ctrl;
    logic               rd_ctrl;
    logic [MODE_W-1:0]  new_mode;
    logic               new_isel;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign rd_ctrl  = bus_rd && (bus_addr == A_CTRL);
    assign new_mode = bus_wdata[MODE_W-1:0];
    assign new_isel = bus_wdata[ISEL_BIT];

    // comparators disabled: outputs forced low before snapshot and compare
    assign cmp_live = (mode_q == OFF_MODE) ? '0 : cmp_sync;

    always_comb begin
        reconfig = wr_ctrl && ((new_mode != mode_q) || (new_isel != isel_q));
        clr_req  = bus_wr && (bus_addr == A_FLAG) && bus_wdata[FLAG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= OFF_MODE;
            isel_q <= 1'b0;
            ien_q  <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                mode_q <= new_mode;
                isel_q <= new_isel;
            end
            if (bus_addr == A_IEN) begin
                ien_q <= bus_wdata[IEN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (rd_ctrl) begin
            ref_q <= cmp_live;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[MODE_W-1:0]          = mode_q;
                    bus_rdata[ISEL_BIT]            = isel_q;
                    bus_rdata[OUT_LSB +: NUM_CMP]  = cmp_live;
                end
                A_FLAG:  bus_rdata[FLAG_BIT] = flag;
                A_IEN:   bus_rdata[IEN_BIT]  = ien_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign cmp_ref = ref_q;
    assign mode    = mode_q;
    assign in_sel  = isel_q;
    assign irq_en  = ien_q;

    // R2
    ref_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (cmp_ref == $past(cmp_live)));

    // R2
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ctrl |=> $stable(cmp_ref));

endmodule

// File: rtl/cmpirq_flag.sv
module cmpirq_flag
    import cmpirq_pkg::*;
#(
    parameter int NUM_CMP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_live,
    input  logic [NUM_CMP-1:0] cmp_ref,
    input  logic               reconfig,
    input  logic               clr_req,
    output logic               flag,
    output logic               mismatch
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        set_req;

    assign mismatch = |(cmp_live ^ cmp_ref);
    assign set_req  = mismatch || reconfig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (mismatch)      state_d = FL_RAISED;
                else if (reconfig) state_d = FL_ARMED;
            end
            FL_RAISED, FL_ARMED: begin
                if (set_req)       state_d = mismatch ? FL_RAISED : FL_ARMED;
                else if (clr_req)  state_d = FL_IDLE;
                else               state_d = FL_ARMED;
            end
            default:               state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_RAISED, FL_ARMED: flag = 1'b1;
            default:             flag = 1'b0;
        endcase
    end

    // R3
    mismatch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag);

    // R6
    reconfig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |=> flag);

    // R4
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && mismatch) |=> flag);

    // R5
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_req));

endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
    import cmpirq_pkg::*;
#(
    parameter int NUM_CMP     = 2,
    parameter int MODE_W      = 3,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_raw,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);

    localparam logic [MODE_W-1:0] OFF_MODE = '1;

    logic [NUM_CMP-1:0] cmp_sync;
    logic [NUM_CMP-1:0] cmp_live;
    logic [NUM_CMP-1:0] cmp_ref;
    logic [MODE_W-1:0]  mode;
    logic               in_sel;
    logic               reconfig;
    logic               clr_req;
    logic               irq_en;
    logic               flag;
    logic               mismatch;

    cmpirq_sync #(
        .WIDTH  (NUM_CMP),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (cmp_sync)
    );

    cmpirq_regs #(
        .NUM_CMP  (NUM_CMP),
        .MODE_W   (MODE_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .OFF_MODE (OFF_MODE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_sync  (cmp_sync),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .bus_rdata (bus_rdata),
        .cmp_live  (cmp_live),
        .cmp_ref   (cmp_ref),
        .mode      (mode),
        .in_sel    (in_sel),
        .reconfig  (reconfig),
        .clr_req   (clr_req),
        .irq_en    (irq_en)
    );

    cmpirq_flag #(
        .NUM_CMP (NUM_CMP)
    ) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_live (cmp_live),
        .cmp_ref  (cmp_ref),
        .reconfig (reconfig),
        .clr_req  (clr_req),
        .flag     (flag),
        .mismatch (mismatch)
    );

    assign irq = flag & irq_en;

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OFF_MODE) && $stable(mode) && $stable(in_sel) && !flag && !bus_wr) |=> !flag);

endmodule

// File: tb/cmp_change_irq_test.sv
module cmp_change_irq_test;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = 2'b00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    item_t sb_q[$];
    logic  probe_on = 1'b0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_change_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_raw   (cmp_raw),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares results against the scoreboard queue
    always @(negedge clk) begin
        #1;
        if (probe_on && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmp(input logic [1:0] v);
        @(negedge clk);
        cmp_raw = v;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a; probe_on = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; probe_on = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        probe_on = 1'b1;
        @(negedge clk);
        probe_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        expect_read(2'd0, 8'h07, "R1 reset ctrl");
        expect_read(2'd1, 8'h00, "R1 reset flag");
        expect_irq(1'b0, "R1 reset irq");

        bus_write(2'd0, 8'h02);
        expect_read(2'd1, 8'h01, "R6 mode change sets flag");
        expect_read(2'd0, 8'h02, "R2 ctrl read");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R5 clear accepted");

        set_cmp(2'b01);
        idle(4);
        expect_irq(1'b0, "R8 flag set but enable low");
        expect_read(2'd1, 8'h01, "R3 mismatch sets flag");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h01, "R4 clear blocked by mismatch");
        expect_read(2'd0, 8'h12, "R2 live bit 4");
        bus_write(2'd1, 8'h00);
        expect_read(2'd1, 8'h01, "R5 zero write no clear");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R5 clear after read");

        set_cmp(2'b00);
        idle(4);
        set_cmp(2'b01);
        idle(4);
        expect_read(2'd1, 8'h01, "R3 sticky after pulse");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R5 clear after self-resolve");

        bus_write(2'd2, 8'h01);
        expect_read(2'd2, 8'h01, "R8 enable readback");
        set_cmp(2'b11);
        idle(4);
        expect_irq(1'b1, "R8 irq raised");
        expect_read(2'd0, 8'h32, "R2 both live bits");
        bus_write(2'd1, 8'h01);
        expect_irq(1'b0, "R8 irq dropped");

        bus_write(2'd0, 8'h0A);
        expect_read(2'd1, 8'h01, "R6 input-select toggle");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R5 clear after toggle");
        bus_write(2'd0, 8'h0A);
        expect_read(2'd1, 8'h00, "R7 unchanged rewrite");

        bus_write(2'd0, 8'hF2);
        expect_read(2'd0, 8'h32, "R9 read-only bits ignored");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R5 clear");

        bus_write(2'd0, 8'h07);
        expect_read(2'd0, 8'h07, "R10 off mode masks outputs");
        bus_write(2'd1, 8'h01);
        expect_read(2'd1, 8'h00, "R10 clear in off mode");
        set_cmp(2'b00);
        idle(4);
        expect_read(2'd1, 8'h00, "R10 fall ignored");
        set_cmp(2'b11);
        idle(4);
        expect_read(2'd1, 8'h00, "R10 rise ignored");

        expect_read(2'd3, 8'h00, "R9 unused address");

        idle(2);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule